// File: doc/BRIEF.md
# Stereo Digital Zero Detector

The block watches a stereo stream headed for a digital-to-analog converter. Each frame carries one left word and one right word. A frame strobe marks the clock cycle in which the pair is valid. The strobe fires once per sample period.

A frame is silent when both words are all zero. The block counts unbroken runs of silent frames. It raises its zero flag once the run reaches a set length, which is 8192 frames by default. Downstream logic can use the flag to mute or to save power.

Any frame with a nonzero word ends the run and drops the flag at once. While the converter is powered down, the flag is held low and the run count is discarded.

Top module: `stereo_zero_detect`

## Requirements
- R1: After a synchronous active-low reset, the flag is low and the run count is zero. A full run of RUN_LEN silent frames is needed before the flag rises.
- R2: A frame is silent only if the left and right words are both exactly zero. A frame with only one channel at zero ends the run, and so does a single set bit in either word at any bit position.
- R3: The flag goes high at the clock edge that samples the RUN_LEN-th consecutive silent frame. It is visible right after that edge, and not one frame earlier.
- R4: A strobed frame that is not silent clears both the run count and the flag at the edge that samples it.
- R5: The run count saturates at RUN_LEN. The flag stays high through any number of further silent frames.
- R6: While `dac_pwrdn` is high, `zero_flag` is low. This holds in the same cycle, before any clock edge.
- R7: Each clock edge with `dac_pwrdn` high clears the run count. After power-down ends, a full new run of RUN_LEN silent frames is needed.
- R8: Without `frame_stb`, the run count and the flag do not change, whatever the sample inputs carry.
- R9: When `dac_pwrdn` and a strobed silent frame arrive in the same cycle, power-down wins. The frame does not add to the run, even if it would have completed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | High for one cycle per frame; the samples are valid in that cycle |
| left_smp | input | SAMPLE_W | Left channel sample word |
| right_smp | input | SAMPLE_W | Right channel sample word |
| dac_pwrdn | input | 1 | Converter power-down; high forces the flag low and clears the run |
| zero_flag | output | 1 | High after RUN_LEN consecutive silent frames |

## Verification
Two functions can fall in the same cycle. Power-down clearing can coincide with a strobed silent frame that would complete the run. A nonzero frame can also coincide with the edge that would otherwise raise the flag.

The bench provokes both cases. It builds a run to RUN_LEN-1 silent frames, then delivers the completing frame in the same cycle as `dac_pwrdn`, or delivers a nonzero frame in its place. It judges the outcome at the port: the flag must stay low. It then checks that a whole new run is needed, using a reference count kept in the bench.

// File: rtl/szd_pkg.sv
// Package: shared helpers for the stereo zero detector.
// Assumes: run lengths are positive integers.
package szd_pkg;

    // Number of bits needed to hold values 0..max_val inclusive.
    function automatic int run_cnt_width(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/szd_frame_classify.sv
// Module: decides whether a stereo frame is silent (every channel word zero).
// Assumes: samples are valid whenever the caller strobes; output is combinational.
module szd_frame_classify #(
    parameter int SAMPLE_W = 24,
    parameter int CHANNELS = 2
) (
    input  logic [CHANNELS-1:0][SAMPLE_W-1:0] smp,
    output logic                              all_zero
);

    logic [CHANNELS-1:0] ch_zero;

    // One zero comparator per channel word.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        assign ch_zero[c] = (smp[c] == '0);
    end

    // The frame is silent only when every channel is zero.
    always_comb all_zero = &ch_zero;

endmodule

// File: rtl/szd_run_counter.sv
// Module: saturating count of consecutive silent frames.
// Assumes: stb marks one frame per pulse; pwrdn takes priority over frames.
// Also reports whether the next count reaches the run length.
module szd_run_counter #(
    parameter int RUN_LEN = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic silent,
    input  logic pwrdn,
    output logic hit_nxt
);
    import szd_pkg::*;

    localparam int CNT_W = run_cnt_width(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Next count: power-down clears, a nonzero frame clears, a silent frame adds and saturates.
    always_comb begin
        cnt_nxt = cnt_q;
        if (pwrdn) begin
            cnt_nxt = '0;
        end else if (stb) begin
            if (!silent)
                cnt_nxt = '0;
            else if (cnt_q != CNT_MAX)
                cnt_nxt = cnt_q + 1'b1;
        end
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // Flags a count that will reach the run length at this edge.
    always_comb hit_nxt = (cnt_nxt == CNT_MAX);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    p_clear_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !silent) |=> (cnt_q == '0));
    p_pd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> (cnt_q == '0));
    p_hold_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !pwrdn) |=> $stable(cnt_q));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && silent && !pwrdn && cnt_q == CNT_MAX - 1'b1) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/szd_flag.sv
// Module: holds the zero flag and gates it with power-down.
// Assumes: hit_nxt comes from the run counter for the current cycle.
module szd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pwrdn,
    input  logic hit_nxt,
    output logic flag
);

    logic flag_q;

    // Flag register: cleared by power-down, updated only on frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (pwrdn) flag_q <= 1'b0;
        else if (stb)   flag_q <= hit_nxt;
    end

    // Power-down forces the output low in the same cycle.
    always_comb flag = flag_q && !pwrdn;

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !pwrdn) |=> $stable(flag_q));
    p_flag_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit_nxt && stb));
    p_flag_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !flag_q);

endmodule

// File: rtl/stereo_zero_detect.sv
// Module: top of the stereo zero detector.
// Raises zero_flag after RUN_LEN strobed frames in which both channels are zero.
// Assumes: one frame_stb pulse per sample period; all inputs synchronous to clk.
module stereo_zero_detect #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                dac_pwrdn,
    output logic                zero_flag
);

    logic [1:0][SAMPLE_W-1:0] smp_pair;
    logic                     silent;
    logic                     hit_nxt;

    // Pack both channels for the classifier.
    always_comb smp_pair = {right_smp, left_smp};

    szd_frame_classify #(.SAMPLE_W(SAMPLE_W), .CHANNELS(2)) u_classify (
        .smp      (smp_pair),
        .all_zero (silent)
    );

    szd_run_counter #(.RUN_LEN(RUN_LEN)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (frame_stb),
        .silent  (silent),
        .pwrdn   (dac_pwrdn),
        .hit_nxt (hit_nxt)
    );

    szd_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (frame_stb),
        .pwrdn   (dac_pwrdn),
        .hit_nxt (hit_nxt),
        .flag    (zero_flag)
    );

    p_nonzero_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (left_smp != '0 || right_smp != '0)) |=> !zero_flag);
    p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && ((left_smp == '0) != (right_smp == '0))) |=> !zero_flag);

endmodule

// File: tb/stereo_zero_detect_bench.sv
module stereo_zero_detect_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 8;
    localparam int RUN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [SW-1:0] lft = '0;
    logic [SW-1:0] rgt = '0;
    logic          pd = 1'b0;
    logic          zf;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    bit m_flag = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_zero_detect #(.SAMPLE_W(SW), .RUN_LEN(RUN)) u_stereo_zero_detect (
        .clk(clk), .rst_n(rst_n), .frame_stb(stb), .left_smp(lft),
        .right_smp(rgt), .dac_pwrdn(pd), .zero_flag(zf)
    );

    task automatic check(input string req, input bit exp);
        n_chk++;
        if (zf !== exp) begin
            n_fail++;
            $display("FAIL %s: zero_flag=%b expected=%b at %0t", req, zf, exp, $time);
        end
    endtask

    // Drive one cycle at negedge, check before and after the edge against the model.
    task automatic step(input bit s, input logic [SW-1:0] l, input logic [SW-1:0] r,
                        input bit p, input string req);
        @(negedge clk);
        stb = s; lft = l; rgt = r; pd = p;
        #1 check(req, m_flag && !p);
        @(posedge clk);
        if (p) begin
            m_cnt = 0; m_flag = 1'b0;
        end else if (s) begin
            if (l == 0 && r == 0) begin
                if (m_cnt < RUN) m_cnt++;
                m_flag = (m_cnt == RUN);
            end else begin
                m_cnt = 0; m_flag = 1'b0;
            end
        end
        #1 check(req, m_flag && !p);
    endtask

    task automatic zeros(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, '0, '0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        zeros(RUN - 1, "R1");
        check("R1", 1'b0);
        zeros(1, "R3");
        check("R3", 1'b1);

        // R3/R4/R8: sweep run length k, with idle gaps carrying nonzero junk
        for (int k = 0; k <= RUN + 2; k++) begin
            step(1'b1, 8'h01, '0, 1'b0, "R4");
            for (int i = 0; i < k; i++) begin
                step(1'b1, '0, '0, 1'b0, "R3");
                step(1'b0, 8'(i + 1), 8'hA5, 1'b0, "R8");
            end
            check((k >= RUN) ? "R3" : "R4", k >= RUN);
            step(1'b1, '0, 8'h10, 1'b0, "R4");
            check("R4", 1'b0);
        end

        // R2: single set bit in either channel, every position, with flag high
        for (int b = 0; b < SW; b++) begin
            for (int side = 0; side < 2; side++) begin
                zeros(RUN, "R2");
                check("R2", 1'b1);
                step(1'b1, side == 0 ? 8'(1 << b) : 8'h00,
                           side == 1 ? 8'(1 << b) : 8'h00, 1'b0, "R2");
                check("R2", 1'b0);
            end
        end

        // R5: saturation
        zeros(3 * RUN + 5, "R5");
        check("R5", 1'b1);

        // R6: same-cycle power-down gating, no edge needed
        @(negedge clk); pd = 1'b1; stb = 1'b0;
        #1 check("R6", 1'b0);
        // R7: after power-down a full new run is needed
        step(1'b0, '0, '0, 1'b1, "R7");
        zeros(RUN - 1, "R7");
        check("R7", 1'b0);
        zeros(1, "R7");
        check("R7", 1'b1);

        // R9: completing frame coincides with power-down
        step(1'b1, 8'h3, '0, 1'b0, "R9");
        zeros(RUN - 1, "R9");
        step(1'b1, '0, '0, 1'b1, "R9");
        check("R9", 1'b0);
        zeros(RUN - 1, "R9");
        check("R9", 1'b0);
        zeros(1, "R9");
        check("R9", 1'b1);

        // R4: nonzero frame in place of the completing frame
        step(1'b1, '0, 8'h80, 1'b0, "R4");
        zeros(RUN - 1, "R4");
        step(1'b1, 8'h40, 8'h40, 1'b0, "R4");
        check("R4", 1'b0);

        // R1: reset mid-run clears everything
        zeros(RUN, "R1");
        @(negedge clk); rst_n = 1'b0; stb = 1'b0;
        @(posedge clk); #1 m_cnt = 0; m_flag = 1'b0; check("R1", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        zeros(RUN - 1, "R1");
        check("R1", 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule